// File: doc/BRIEF.md
# Asynchronous External Memory Write Sequencer

This block is a bus master that carries out single writes to asynchronous external memory or to memory-mapped peripherals. It runs from a phase clock with four ticks per external bus cycle, so the address, the strobe and the data bus can move on quarter-cycle boundaries. A write request carries the address, the write data, a chip-select index, a wait-state count and two enables. One enable adds an address-hold bus cycle and the other adds a bus-idle turnaround cycle.

Requests arrive on a valid/ready handshake. `req_ready` is high only while the sequencer is idle. A request is taken on any clock edge where `req_valid` and `req_ready` are both high. All request fields are latched at that edge. The requester must hold the fields stable while `req_valid` is high and `req_ready` is low. Outside an access, `req_valid` has no effect. After the write and any hold or idle cycles, the block pulses `done` for one cycle, with `done_err` marking an access that was aborted.

The external ACK line is asynchronous and passes through a two-flop synchronizer. The sequencer ignores ACK while the programmed wait states run out. After that, it keeps the strobe low until ACK is seen high or a timeout expires.

Top module: `aw_write_seq`

## Requirements
- R1: The selected chip select (active low, bit `req_sel` of `mem_cs_n`, all other bits high) is driven one tick before `mem_wr_n` falls. `mem_wr_n` is low only while exactly that one select is low.
- R2: With ACK high, `mem_wr_n` stays low for exactly `BASE_TICKS + 4*cfg_wait` ticks. `mem_dq_oe` is high and `mem_addr`/`mem_dq_o` carry the latched request throughout.
- R3: A low level on ACK that is seen by the synchronizer only during the wait-state window does not lengthen the strobe.
- R4: When ACK is low at the end of the wait window, the strobe continues. If ACK is raised during low tick c (1-based), the strobe width is max(N, c+2), where N is the base width from R2 and the 2 is the synchronizer latency.
- R5: After `mem_wr_n` rises, the chip select and `mem_dq_oe` stay active for 1 tick, or for 5 ticks when `cfg_hold_en` was set.
- R6: With `cfg_idle_en` set, 4 further ticks with the bus released follow the hold, before `done` is asserted and before a new strobe can start.
- R7: `done` is a single-cycle pulse. It comes 1 + 4·hold + 4·idle ticks after the tick in which `mem_wr_n` rises.
- R8: `req_ready` is high only while idle. A `req_valid` raised during an access is neither accepted nor able to change the write in progress.
- R9: If ACK is still low after `4*TMO_BUS` ticks past the wait window, the access aborts. The strobe width is then N + 4·TMO_BUS. The select, the strobe and the data enable are released on the following tick, and `done` pulses together with `done_err` in that same tick.
- R10: After reset, `mem_wr_n` is high, all of `mem_cs_n` are high, `mem_dq_oe`, `done` and `done_err` are low, and `req_ready` is high.
- R11: A wait count of zero gives a strobe of exactly `BASE_TICKS` ticks, and ACK is sampled at its end.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Phase clock, four ticks per bus cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Write request valid |
| req_ready | output | 1 | Sequencer idle, request can be taken |
| req_addr | input | ADDR_W | Write address |
| req_data | input | DATA_W | Write data |
| req_sel | input | $clog2(NUM_CS) | Chip-select index |
| cfg_wait | input | WAIT_W | Wait states, in bus cycles |
| cfg_hold_en | input | 1 | Insert an address-hold bus cycle |
| cfg_idle_en | input | 1 | Insert a bus-idle bus cycle |
| mem_addr | output | ADDR_W | External address |
| mem_cs_n | output | NUM_CS | Active-low chip selects |
| mem_wr_n | output | 1 | Active-low write strobe |
| mem_dq_o | output | DATA_W | Write data to the bus |
| mem_dq_oe | output | 1 | Data bus output enable |
| mem_ack | input | 1 | Asynchronous acknowledge, high = ready |
| done | output | 1 | One-cycle access-complete pulse |
| done_err | output | 1 | Qualifies `done`: access aborted by timeout |

## Verification
The bench builds the sequencer with `WAIT_W = 3` and `TMO_BUS = 3`. A 3-bit wait field allows strobe widths of 3 to 31 ticks, which covers both the zero-wait edge case and a wait window long enough to hide an ACK pulse inside it. A timeout of three bus cycles makes the abort path take only 12 ticks past the wait window. The error recovery and the accesses that follow it therefore fit into a short run.

// File: rtl/aw_pkg.sv
package aw_pkg;
  localparam int unsigned PHASES = 4;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_STROBE,
    ST_TAIL,
    ST_HOLD,
    ST_TURN
  } aw_state_e;
endpackage

// File: rtl/aw_sync.sv
module aw_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], d};
  end

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/aw_down_cnt.sv
module aw_down_cnt #(
  parameter int unsigned W = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         dec,
  output logic         zero
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     cnt_q <= '0;
    else if (load)                  cnt_q <= load_val;
    else if (dec && cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign zero = (cnt_q == '0);

  p_no_dec_at_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (dec && !load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/aw_timeout.sv
module aw_timeout #(
  parameter int unsigned LIMIT = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic en,
  output logic hit
);
  localparam int unsigned TW = $clog2(LIMIT + 1);
  logic [TW-1:0] t_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          t_q <= '0;
    else if (clr)        t_q <= '0;
    else if (en && !hit) t_q <= t_q + 1'b1;
  end

  assign hit = (t_q == TW'(LIMIT));

  p_tmo_bounded_r9: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> (t_q == TW'(LIMIT)) || (t_q == '0));
endmodule

// File: rtl/aw_write_seq.sv
module aw_write_seq
  import aw_pkg::*;
#(
  parameter int unsigned ADDR_W     = 16,
  parameter int unsigned DATA_W     = 16,
  parameter int unsigned NUM_CS     = 4,
  parameter int unsigned WAIT_W     = 4,
  parameter int unsigned BASE_TICKS = 3,
  parameter int unsigned TMO_BUS    = 8,
  localparam int unsigned SEL_W     = $clog2(NUM_CS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_data,
  input  logic [SEL_W-1:0]  req_sel,
  input  logic [WAIT_W-1:0] cfg_wait,
  input  logic              cfg_hold_en,
  input  logic              cfg_idle_en,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [NUM_CS-1:0] mem_cs_n,
  output logic              mem_wr_n,
  output logic [DATA_W-1:0] mem_dq_o,
  output logic              mem_dq_oe,
  input  logic              mem_ack,
  output logic              done,
  output logic              done_err
);
  localparam int unsigned MAX_STROBE = BASE_TICKS + PHASES * ((1 << WAIT_W) - 1);
  localparam int unsigned CNT_W      = $clog2(MAX_STROBE + 1);
  localparam int unsigned TMO_TICKS  = PHASES * TMO_BUS;

  aw_state_e st_q, st_d;

  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;
  logic [SEL_W-1:0]  sel_q;
  logic [WAIT_W-1:0] wait_q;
  logic              hold_q, idle_q;
  logic              done_q, err_q;

  logic              ack_s;
  logic              ld, dec, cnt_zero;
  logic [CNT_W-1:0]  ld_val;
  logic              tmo_hit, tmo_en, tmo_clr;
  logic              fin, fin_err;
  logic [CNT_W-1:0]  strobe_len;

  aw_sync #(.STAGES(2)) u_ack_sync (
    .clk(clk), .rst_n(rst_n), .d(mem_ack), .q(ack_s)
  );

  aw_down_cnt #(.W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .load(ld), .load_val(ld_val),
    .dec(dec), .zero(cnt_zero)
  );

  aw_timeout #(.LIMIT(TMO_TICKS)) u_tmo (
    .clk(clk), .rst_n(rst_n), .clr(tmo_clr), .en(tmo_en), .hit(tmo_hit)
  );

  assign strobe_len = CNT_W'(BASE_TICKS) + CNT_W'(wait_q) * CNT_W'(PHASES);
  assign tmo_clr    = (st_q != ST_STROBE);
  assign tmo_en     = (st_q == ST_STROBE) && cnt_zero && !ack_s;

  always_comb begin
    st_d    = st_q;
    ld      = 1'b0;
    ld_val  = '0;
    dec     = 1'b0;
    fin     = 1'b0;
    fin_err = 1'b0;
    unique case (st_q)
      ST_IDLE: if (req_valid) st_d = ST_SETUP;
      ST_SETUP: begin
        ld     = 1'b1;
        ld_val = strobe_len - 1'b1;
        st_d   = ST_STROBE;
      end
      ST_STROBE: begin
        if (!cnt_zero) dec = 1'b1;
        else if (ack_s) st_d = ST_TAIL;
        else if (tmo_hit) begin
          st_d = ST_IDLE; fin = 1'b1; fin_err = 1'b1;
        end
      end
      ST_TAIL: begin
        if (hold_q) begin
          ld = 1'b1; ld_val = CNT_W'(PHASES - 1); st_d = ST_HOLD;
        end else if (idle_q) begin
          ld = 1'b1; ld_val = CNT_W'(PHASES - 1); st_d = ST_TURN;
        end else begin
          st_d = ST_IDLE; fin = 1'b1;
        end
      end
      ST_HOLD: begin
        if (!cnt_zero) dec = 1'b1;
        else if (idle_q) begin
          ld = 1'b1; ld_val = CNT_W'(PHASES - 1); st_d = ST_TURN;
        end else begin
          st_d = ST_IDLE; fin = 1'b1;
        end
      end
      ST_TURN: begin
        if (!cnt_zero) dec = 1'b1;
        else begin st_d = ST_IDLE; fin = 1'b1; end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      addr_q <= '0;
      data_q <= '0;
      sel_q  <= '0;
      wait_q <= '0;
      hold_q <= 1'b0;
      idle_q <= 1'b0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      done_q <= fin;
      err_q  <= fin_err;
      if (st_q == ST_IDLE && req_valid) begin
        addr_q <= req_addr;
        data_q <= req_data;
        sel_q  <= req_sel;
        wait_q <= cfg_wait;
        hold_q <= cfg_hold_en;
        idle_q <= cfg_idle_en;
      end
    end
  end

  logic cs_act;
  assign cs_act    = (st_q == ST_SETUP) || (st_q == ST_STROBE) ||
                     (st_q == ST_TAIL)  || (st_q == ST_HOLD);
  assign mem_cs_n  = cs_act ? ~(NUM_CS'(1) << sel_q) : '1;
  assign mem_wr_n  = (st_q != ST_STROBE);
  assign mem_dq_oe = (st_q == ST_STROBE) || (st_q == ST_TAIL) || (st_q == ST_HOLD);
  assign mem_addr  = addr_q;
  assign mem_dq_o  = data_q;
  assign req_ready = (st_q == ST_IDLE);
  assign done      = done_q;
  assign done_err  = err_q;

  p_strobe_one_select_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_wr_n |-> ($countones(~mem_cs_n) == 1));

  p_select_before_strobe_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_wr_n) |-> ($past(mem_cs_n) == mem_cs_n) && ($past(mem_cs_n) != '1));

  p_ack_ignored_in_wait_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_wr_n && !cnt_zero) |=> !mem_wr_n);

  p_oe_needs_select_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> (mem_cs_n != '1));

  p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_ready_bus_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (mem_cs_n == '1) && mem_wr_n && !mem_dq_oe);

  p_err_with_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done_err |-> done);
endmodule

// File: tb/tb_aw_write_seq.sv
module tb_aw_write_seq;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 16;
  localparam int DATA_W = 16;
  localparam int NUM_CS = 4;
  localparam int WAIT_W = 3;
  localparam int BASE   = 3;
  localparam int TMO    = 3;
  localparam int SEL_W  = $clog2(NUM_CS);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [DATA_W-1:0] req_data = '0;
  logic [SEL_W-1:0]  req_sel = '0;
  logic [WAIT_W-1:0] cfg_wait = '0;
  logic cfg_hold_en = 1'b0, cfg_idle_en = 1'b0;
  logic [ADDR_W-1:0] mem_addr;
  logic [NUM_CS-1:0] mem_cs_n;
  logic mem_wr_n;
  logic [DATA_W-1:0] mem_dq_o;
  logic mem_dq_oe;
  logic mem_ack = 1'b1;
  logic done, done_err;

  always #(CLK_PERIOD/2) clk = ~clk;

  aw_write_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_CS(NUM_CS),
                 .WAIT_W(WAIT_W), .BASE_TICKS(BASE), .TMO_BUS(TMO)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_data(req_data), .req_sel(req_sel),
    .cfg_wait(cfg_wait), .cfg_hold_en(cfg_hold_en), .cfg_idle_en(cfg_idle_en),
    .mem_addr(mem_addr), .mem_cs_n(mem_cs_n), .mem_wr_n(mem_wr_n),
    .mem_dq_o(mem_dq_o), .mem_dq_oe(mem_dq_oe), .mem_ack(mem_ack),
    .done(done), .done_err(done_err)
  );

  typedef struct {
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
    logic [NUM_CS-1:0] cs_n;
    int width;
    int post;
    int cpost;
    bit err;
    string tag;
  } exp_t;

  exp_t q[$];
  int n_checks = 0;
  int n_fail   = 0;

  // ACK control: 0 high, 1 low until low tick a, 2 low during ticks [a,b), 3 stuck low
  int ack_mode = 0, ack_a = 0, ack_b = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  endtask

  // Monitor
  bit prev_wr = 1'b1, prev_cs = 1'b0, in_post = 1'b0, oe_bad = 1'b0, setup_ok = 1'b0;
  logic [NUM_CS-1:0] prev_cs_n = '1;
  int low = 0, post = 0, cpost = 0, opost = 0;
  logic [ADDR_W-1:0] cap_addr;
  logic [DATA_W-1:0] cap_data;
  logic [NUM_CS-1:0] cap_cs;

  always @(negedge clk) begin
    if (rst_n) begin
      bit cs_on;
      cs_on = (mem_cs_n != '1);
      if (!mem_wr_n) begin
        if (prev_wr) begin
          low = 1; in_post = 1'b0; oe_bad = 1'b0;
          setup_ok = prev_cs && (prev_cs_n == mem_cs_n);
          cap_addr = mem_addr; cap_data = mem_dq_o; cap_cs = mem_cs_n;
        end else begin
          low++;
          if (mem_cs_n != cap_cs || mem_addr != cap_addr || mem_dq_o != cap_data) oe_bad = 1'b1;
        end
        if (!mem_dq_oe) oe_bad = 1'b1;
        if (ack_mode == 1 && low == ack_a) mem_ack = 1'b1;
        if (ack_mode == 2 && low == ack_a) mem_ack = 1'b0;
        if (ack_mode == 2 && low == ack_b) mem_ack = 1'b1;
      end else begin
        if (!prev_wr) begin
          in_post = 1'b1; post = 0; cpost = 0; opost = 0;
        end
        if (in_post) begin
          if (done) begin
            if (q.size() == 0) begin
              chk(1'b0, "R7 unexpected done", 1, 0);
            end else begin
              exp_t e;
              e = q.pop_front();
              chk(setup_ok, {e.tag, " R1 select one tick before strobe"}, setup_ok, 1);
              chk(cap_cs == e.cs_n, {e.tag, " R1 chip select"}, cap_cs, e.cs_n);
              chk(cap_addr == e.addr, {e.tag, " R2 address"}, cap_addr, e.addr);
              chk(cap_data == e.data, {e.tag, " R2 data"}, cap_data, e.data);
              chk(!oe_bad, {e.tag, " R2 bus stable with oe during strobe"}, oe_bad, 0);
              chk(low == e.width, {e.tag, " R2/R4 strobe width"}, low, e.width);
              chk(cpost == e.cpost, {e.tag, " R5 select hold"}, cpost, e.cpost);
              chk(opost == e.cpost, {e.tag, " R5 data enable hold"}, opost, e.cpost);
              chk(post == e.post, {e.tag, " R6/R7 ticks to done"}, post, e.post);
              chk(done_err == e.err, {e.tag, " R9 error flag"}, done_err, e.err);
            end
            in_post = 1'b0;
          end else begin
            post++;
            if (cs_on) cpost++;
            if (mem_dq_oe) opost++;
          end
        end else if (done) begin
          chk(1'b0, "R7 done without strobe", 1, 0);
        end
      end
      prev_wr = mem_wr_n; prev_cs = cs_on; prev_cs_n = mem_cs_n;
    end
  end

  task automatic do_write(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d,
                          input int sel, input int w, input bit h, input bit i,
                          input int mode, input int pa, input int pb,
                          input bit poke, input string tag);
    exp_t e;
    int n;
    n = BASE + 4 * w;
    e.addr = a; e.data = d; e.cs_n = ~(NUM_CS'(1) << sel);
    e.err = (mode == 3); e.tag = tag;
    if (mode == 1)      e.width = (n > pa + 2) ? n : pa + 2;
    else if (mode == 3) e.width = n + 4 * TMO;
    else                e.width = n;
    e.cpost = e.err ? 0 : 1 + 4 * h;
    e.post  = e.err ? 0 : 1 + 4 * h + 4 * i;
    q.push_back(e);
    @(negedge clk);
    ack_mode = mode; ack_a = pa; ack_b = pb;
    mem_ack = (mode == 0 || mode == 2);
    req_addr = a; req_data = d; req_sel = SEL_W'(sel);
    cfg_wait = WAIT_W'(w); cfg_hold_en = h; cfg_idle_en = i;
    req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    req_addr = ~a; req_data = ~d; req_sel = ~SEL_W'(sel);
    cfg_wait = ~WAIT_W'(w); cfg_hold_en = ~h; cfg_idle_en = ~i;
    if (poke) begin
      req_valid = 1'b1;
      for (int k = 0; k < 4; k++) begin
        chk(!req_ready, {tag, " R8 ready low while busy"}, req_ready, 0);
        @(negedge clk);
      end
      req_valid = 1'b0;
    end
    while (q.size() != 0) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    chk(mem_wr_n == 1'b1, "R10 wr_n after reset", mem_wr_n, 1);
    chk(mem_cs_n == '1, "R10 cs_n after reset", mem_cs_n, 4'hF);
    chk(mem_dq_oe == 1'b0, "R10 oe after reset", mem_dq_oe, 0);
    chk(req_ready == 1'b1, "R10 ready after reset", req_ready, 1);
    chk(done == 1'b0 && done_err == 1'b0, "R10 done after reset", done, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    do_write(16'h1234, 16'hA5A5, 0, 0, 0, 0, 0, 0, 0, 0, "R11 zero wait");
    do_write(16'h0F0F, 16'h5A5A, 1, 2, 1, 0, 0, 0, 0, 0, "R5 hold");
    do_write(16'hBEEF, 16'h0001, 2, 1, 0, 1, 0, 0, 0, 0, "R6 idle");
    do_write(16'h4444, 16'h7777, 3, 3, 0, 0, 2, 2, 8, 0, "R3 ack pulse in wait");
    do_write(16'h1111, 16'h2222, 1, 1, 0, 0, 1, 10, 0, 0, "R4 ack stretch");
    do_write(16'h3333, 16'h4444, 0, 0, 0, 0, 1, 1, 0, 0, "R11 ack at zero wait");
    do_write(16'hDEAD, 16'hC0DE, 2, 1, 1, 1, 3, 0, 0, 0, "R9 timeout");
    do_write(16'h5555, 16'h6666, 3, 3, 0, 0, 0, 0, 0, 1, "R8 busy poke");
    do_write(16'hFFFF, 16'h8001, 3, 7, 1, 1, 0, 0, 0, 0, "R2 max wait");
    do_write(16'h0000, 16'hFFFF, 0, 0, 0, 1, 0, 0, 0, 0, "R6 idle back to back");
    repeat (5) @(negedge clk);
    chk(q.size() == 0, "R7 all accesses completed", q.size(), 0);
    summary();
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired R7 actual=%0d expected=%0d", 1, 0);
    summary();
  end
endmodule